// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a stream of 10-bit parallel words into a single serial bit stream with framing that lets a receiver recover timing from the data itself. Each word goes out as a 12-bit frame: a leading 1, the ten data bits least significant first, and a trailing 0. The guaranteed 1-to-0 step at every frame boundary is what a receiver locks onto. The block runs from one fast clock. An internal bit enable, one pulse per `CLK_PER_BIT` clocks, steps the shifter, and no phase-locked loop is modelled.

Words arrive on a word strobe (`word_clk`), which is sampled as an ordinary synchronous level. `strobe_rise` chooses whether a rising or a falling transition of that strobe latches `din` into a holding register. The word rate is fixed by the strobe, so there is no valid/ready handshake and no back-pressure. The last word latched before a frame boundary is the word sent, and a word that is overwritten before a boundary is lost.

A request on either `sync_a` or `sync_b` replaces data with lock symbols (six 1s then six 0s) for at least `LOCK_MIN` frames, and for longer if the request is held. `ser_en` gates the line output. `pd_n` puts the block to sleep, clears its frame position and lock count, and silences the line. The output-enable flag `ser_oe` stands in for a high-impedance line driver.

Top module: `emb_serializer`

## Requirements
- R1: After reset and whenever powered up, frames follow back to back with no gap. With the default `CLK_PER_BIT` of 1 there is one bit per clock. Each frame puts 1 on `ser_out` first, then `din` bits 0 through 9 in that order, then 0.
- R2: With `strobe_rise`=1, a 0-to-1 transition of `word_clk` latches `din`. A 1-to-0 transition leaves the latched word unchanged.
- R3: With `strobe_rise`=0, a 1-to-0 transition of `word_clk` latches `din`. A 0-to-1 transition leaves the latched word unchanged.
- R4: A new frame is loaded only at a frame boundary, from the word held at that boundary. Frames are never cut short.
- R5: While `ser_en` is low, `ser_oe` and `ser_out` are 0 from the next clock edge onward. The frame timing keeps running, so the first frame after `ser_en` returns high is whole and carries the most recently latched word.
- R6: While `pd_n` is low, `ser_oe` and `ser_out` are 0 from the next edge, and sync requests are ignored. When `pd_n` rises, the frame position and the lock count restart: the first bit of a fresh data frame appears one edge later.
- R7: A rising sync request makes the next frame boundary start a burst of lock symbols. A lock symbol is a frame whose bits 0 to 5, as sent in order, are 1 and whose bits 6 to 11 are 0. A single-cycle request gives exactly `LOCK_MIN` (1024) lock frames, and then data resumes.
- R8: While a sync request stays high, lock frames continue beyond `LOCK_MIN`. Data resumes at the first boundary where the request is low and the count has been reached.
- R9: `sync_a` and `sync_b` are combined by logical OR: either one alone starts a burst.
- R10: A new rising sync request during a burst restarts the count. A further `LOCK_MIN` lock frames follow the boundary after that rise.
- R11: During reset, `ser_oe` and `ser_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word strobe, sampled synchronously |
| strobe_rise | input | 1 | 1: latch on rising strobe; 0: on falling strobe |
| din | input | DATA_W | Parallel data word |
| ser_en | input | 1 | Line output enable, active high |
| pd_n | input | 1 | Active-low power-down |
| sync_a | input | 1 | Lock request, active high |
| sync_b | input | 1 | Second lock request, ORed with `sync_a` |
| ser_out | output | 1 | Serial bit, 0 while disabled |
| ser_oe | output | 1 | High when the line is driven |

## Verification
The embedded properties assume that `word_clk`, `din` and the control inputs are synchronous to `clk` and change between edges. They also assume that `strobe_rise` is changed only while the strobe sits at its idle level, so that switching it never creates a spurious latching transition. The stimulus changes every input on the falling clock edge. It switches the strobe polarity only during power-down, after moving `word_clk` to the new idle level. The full 10-bit word space is swept under both strobe polarities. Burst lengths are checked frame by frame at exactly `LOCK_MIN`, past it with a held request, and across a restart.

// File: rtl/emb_ser_pkg.sv
package emb_ser_pkg;
  // What the frame loader puts into the shifter at a boundary.
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_DATA = 2'd1,
    LD_LOCK = 2'd2
  } load_kind_e;

  localparam logic FRAME_START_BIT = 1'b1;
  localparam logic FRAME_STOP_BIT  = 1'b0;
endpackage

// File: rtl/emb_ser_capture.sv
module emb_ser_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic              strobe_rise,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hold
);
  logic wclk_q;
  logic saw_rise, saw_fall, take;

  always_comb begin
    saw_rise = word_clk & ~wclk_q;
    saw_fall = ~word_clk & wclk_q;
    take     = strobe_rise ? saw_rise : saw_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q <= 1'b0;
      hold   <= '0;
    end else begin
      wclk_q <= word_clk;
      if (take) hold <= din;
    end
  end

  AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && word_clk && !wclk_q) |=> (hold == $past(din))); // R2
  AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_rise && !word_clk && wclk_q) |=> (hold == $past(din))); // R3
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_clk == wclk_q) |=> $stable(hold)); // R2
endmodule

// File: rtl/emb_ser_timer.sv
module emb_ser_timer #(
  parameter int FRAME_W     = 12,
  parameter int CLK_PER_BIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic bit_en,
  output logic frame_load
);
  localparam int PW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

  logic [PW-1:0] pos;

  generate
    if (CLK_PER_BIT == 1) begin : g_full_rate
      assign bit_en = pd_n;
    end else begin : g_divided
      localparam int DW = $clog2(CLK_PER_BIT);
      localparam logic [DW-1:0] DIV_LAST = DW'(CLK_PER_BIT - 1);
      logic [DW-1:0] div;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div <= '0;
        else if (!pd_n)          div <= '0;
        else if (div == DIV_LAST) div <= '0;
        else                     div <= div + 1'b1;
      end
      assign bit_en = pd_n && (div == DIV_LAST);
    end
  endgenerate

  assign frame_load = bit_en && (pos == LAST);

  // The position starts on the last slot, so the first bit enable after
  // wake-up loads a fresh frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= LAST;
    else if (!pd_n)  pos <= LAST;
    else if (bit_en) pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos != LAST) |=> (pos == $past(pos) + 1'b1)); // R4
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (pos == '0)); // R4
  AST_SLEEP_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (pos == LAST)); // R6
endmodule

// File: rtl/emb_ser_sync.sv
module emb_ser_sync #(
  parameter int LOCK_MIN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic sync_req,
  input  logic frame_load,
  output logic send_lock
);
  localparam int CW = $clog2(LOCK_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(LOCK_MIN);

  logic          sync_q;
  logic          pending;
  logic [CW-1:0] cnt;
  logic [CW-1:0] next_cnt;
  logic          rise;

  always_comb begin
    rise      = sync_req & ~sync_q;
    send_lock = sync_req | pending;
    if (rise)              next_cnt = CW'(1);
    else if (cnt == CMAX)  next_cnt = cnt;
    else                   next_cnt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else if (!pd_n) begin
      sync_q  <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else begin
      sync_q <= sync_req;
      if (frame_load && send_lock) begin
        cnt     <= next_cnt;
        pending <= (next_cnt < CMAX);
      end else if (rise) begin
        cnt     <= '0;
        pending <= 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX); // R7
  AST_PENDING_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (cnt < CMAX)); // R7
  AST_RISE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && rise && !frame_load) |=> (pending && cnt == '0)); // R10
  AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!pending && cnt == '0)); // R6
endmodule

// File: rtl/emb_serializer.sv
module emb_serializer #(
  parameter int DATA_W      = 10,
  parameter int LOCK_MIN    = 1024,
  parameter int CLK_PER_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic              strobe_rise,
  input  logic [DATA_W-1:0] din,
  input  logic              ser_en,
  input  logic              pd_n,
  input  logic              sync_a,
  input  logic              sync_b,
  output logic              ser_out,
  output logic              ser_oe
);
  import emb_ser_pkg::*;

  localparam int FRAME_W   = DATA_W + 2;
  localparam int LOCK_ONES = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] LOCK_SYM =
    {{(FRAME_W - LOCK_ONES){1'b0}}, {LOCK_ONES{1'b1}}};

  logic [DATA_W-1:0]  hold;
  logic               bit_en, frame_load;
  logic               sync_req, send_lock;
  logic [FRAME_W-1:0] sh;
  logic               oe_r;
  load_kind_e         ld_kind;

  assign sync_req = sync_a | sync_b;

  emb_ser_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk),
    .strobe_rise(strobe_rise), .din(din), .hold(hold)
  );

  emb_ser_timer #(.FRAME_W(FRAME_W), .CLK_PER_BIT(CLK_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .bit_en(bit_en), .frame_load(frame_load)
  );

  emb_ser_sync #(.LOCK_MIN(LOCK_MIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .sync_req(sync_req),
    .frame_load(frame_load), .send_lock(send_lock)
  );

  always_comb begin
    if (!frame_load)    ld_kind = LD_NONE;
    else if (send_lock) ld_kind = LD_LOCK;
    else                ld_kind = LD_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      oe_r <= 1'b0;
    end else begin
      oe_r <= pd_n & ser_en;
      if (!pd_n) sh <= '0;
      else begin
        unique case (ld_kind)
          LD_LOCK: sh <= LOCK_SYM;
          LD_DATA: sh <= {FRAME_STOP_BIT, hold, FRAME_START_BIT};
          default: if (bit_en) sh <= sh >> 1;
        endcase
      end
    end
  end

  assign ser_oe  = oe_r;
  assign ser_out = sh[0] & oe_r;

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> sh[0]); // R1
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && sync_req) |=> (sh == LOCK_SYM)); // R8
  AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> (!ser_oe && !ser_out)); // R5
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!ser_oe && !ser_out)); // R6
endmodule

// File: tb/emb_serializer_test.sv
module emb_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int FW = DW + 2;
  localparam int LOCK_N = 1024;
  localparam logic [FW-1:0] LOCK_EXP = 12'h03F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_clk = 1'b0;
  logic strobe_rise = 1'b1;
  logic [DW-1:0] din = '0;
  logic ser_en = 1'b1;
  logic pd_n = 1'b1;
  logic sync_a = 1'b0;
  logic sync_b = 1'b0;
  logic ser_out, ser_oe;

  int vectors = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emb_serializer uut (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .strobe_rise(strobe_rise),
    .din(din), .ser_en(ser_en), .pd_n(pd_n), .sync_a(sync_a), .sync_b(sync_b),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic check(input bit ok, input string req, input logic [FW-1:0] got,
                       input logic [FW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // kind: 0 data frame, 1 lock frame, 2 silent frame.
  // Latches next_d during this frame; optional sync_a pulse; sets ser_en at the end.
  task automatic run_frame(input int kind, input logic [DW-1:0] exp_d,
                           input logic [DW-1:0] next_d, input bit pulse,
                           input bit en_after, input string req);
    logic [FW-1:0] got;
    logic [FW-1:0] exp;
    bit oe_ok;
    oe_ok = 1'b1;
    got = '0;
    for (int j = 0; j < FW; j++) begin
      @(negedge clk);
      got[j] = ser_out;
      if (ser_oe !== (kind != 2)) oe_ok = 1'b0;
      if (j == 0) begin
        din = next_d;
        word_clk = strobe_rise;
        if (pulse) sync_a = 1'b1;
      end
      if (j == 1) begin
        word_clk = ~strobe_rise;
        din = ~next_d;
        sync_a = 1'b0;
      end
      if (j == FW - 1) ser_en = en_after;
    end
    case (kind)
      0:       exp = {1'b0, exp_d, 1'b1};
      1:       exp = LOCK_EXP;
      default: exp = '0;
    endcase
    check((got === exp) && oe_ok, req, got, exp);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v <= 1024; v++) begin
      logic [DW-1:0] e;
      logic [DW-1:0] n;
      e = (v == 0) ? '0 : DW'(v - 1);
      n = DW'(v);
      run_frame(0, e, n, 1'b0, 1'b1, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R11: outputs silent during reset
    repeat (3) @(negedge clk);
    check(!ser_oe && !ser_out, "R11", {10'b0, ser_oe, ser_out}, '0);
    rst_n = 1'b1;

    // R1, R2, R4: full word sweep, rising-edge latch (falling transition carries junk)
    sweep("R2");

    // R3, R6: switch polarity during power-down, then sweep again
    pd_n = 1'b0;
    @(negedge clk);
    check(!ser_oe && !ser_out, "R6", {10'b0, ser_oe, ser_out}, '0);
    strobe_rise = 1'b0;
    word_clk = 1'b1;           // rising transition: must not latch under falling mode
    din = 10'h155;
    @(negedge clk);
    @(negedge clk);
    pd_n = 1'b1;
    sweep("R3");

    // R5: disable the line for one frame, timing continues
    run_frame(0, 10'h000, 10'h2A5, 1'b0, 1'b0, "R5");
    run_frame(2, 10'h000, 10'h13C, 1'b0, 1'b1, "R5");
    run_frame(0, 10'h13C, 10'h13C, 1'b0, 1'b1, "R5");

    // R7, R9: single-cycle pulse on sync_a gives exactly LOCK_N lock frames
    run_frame(0, 10'h13C, 10'h0F1, 1'b1, 1'b1, "R7");
    for (int k = 0; k < LOCK_N; k++) run_frame(1, '0, 10'h0F1, 1'b0, 1'b1, "R7");
    run_frame(0, 10'h0F1, 10'h0F1, 1'b0, 1'b1, "R7");

    // R8, R9: request held on sync_b well past LOCK_N
    sync_b = 1'b1;
    for (int k = 0; k < LOCK_N + 76; k++) run_frame(1, '0, 10'h3C3, 1'b0, 1'b1, "R8");
    sync_b = 1'b0;
    run_frame(0, 10'h3C3, 10'h3C3, 1'b0, 1'b1, "R8");

    // R10: second rise mid-burst restarts the count
    run_frame(0, 10'h3C3, 10'h05A, 1'b1, 1'b1, "R10");
    for (int k = 0; k < 499; k++) run_frame(1, '0, 10'h05A, 1'b0, 1'b1, "R10");
    run_frame(1, '0, 10'h05A, 1'b1, 1'b1, "R10");
    for (int k = 0; k < LOCK_N; k++) run_frame(1, '0, 10'h05A, 1'b0, 1'b1, "R10");
    run_frame(0, 10'h05A, 10'h05A, 1'b0, 1'b1, "R10");

    // R6: sleep mid-burst clears the count; sync during sleep is ignored
    run_frame(0, 10'h05A, 10'h2DD, 1'b1, 1'b1, "R6");
    for (int k = 0; k < 10; k++) run_frame(1, '0, 10'h2DD, 1'b0, 1'b1, "R6");
    pd_n = 1'b0;
    @(negedge clk);
    check(!ser_oe && !ser_out, "R6", {10'b0, ser_oe, ser_out}, '0);
    sync_a = 1'b1;
    @(negedge clk);
    sync_a = 1'b0;
    @(negedge clk);
    check(!ser_oe && !ser_out, "R6", {10'b0, ser_oe, ser_out}, '0);
    pd_n = 1'b1;
    run_frame(0, 10'h2DD, 10'h2DD, 1'b0, 1'b1, "R6");
    run_frame(0, 10'h2DD, 10'h2DD, 1'b0, 1'b1, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule